// File: doc/BRIEF.md
# HARQ Receiver Row-Decode Controller

This block is the front end of a link receiver that protects each 64-bit message with a two-dimensional product code. The transmitter first sends an 88-bit flit that holds four 22-bit row codewords, interleaved bit by bit across the bus. The column check bits are held back at the transmitter. The block separates the flit into its four rows and decodes all four at once with single-error-correcting, double-error-detecting row decoders. It then answers the sender on a triple-redundant acknowledge bus.

When every row holds at most one error, the block corrects the errors, presents the 64-bit message and acknowledges it. When any row reports an uncorrectable pattern, the block keeps the row-decoded codewords and answers with a negative acknowledge. It then treats the next valid flit as the deferred column parity, which arrives zero-padded. The block passes both the stored rows and the column parity to an external iterative decoder through a start/done handshake. The message that decoder returns is forwarded together with an error flag. A flit gets at most one negative acknowledge.

Top module: `harq_row_rx`

## Requirements
- R1: Row r bit p is taken from `rxFlit[p*4 + r]`. Inside a 22-bit row, bit 0 is even parity over the whole row, bits 1, 2, 4, 8 and 16 are Hamming checks, and the 16 data bits occupy the remaining positions 3, 5, 6, 7, 9..15, 17..21 in ascending order. Row r data becomes `outData[16r +: 16]`.
- R2: A single flipped bit in a row, at any position including bit 0, is corrected. This holds independently in each of the four rows within the same flit.
- R3: When all rows are correctable, the block drives `ackValid`=1 with `ackNack`=3'b000. In the same cycle it drives `outValid`=1 with the corrected message and `outErr`=0. These outputs appear one clock after the edge that captured the flit and last one cycle.
- R4: A row is uncorrectable in either of two cases. The first is a nonzero syndrome with even overall parity. The second is odd parity with a syndrome above 21. For an uncorrectable row the block drives `ackValid`=1 with `ackNack`=3'b111, holds `outValid` low and waits for column parity.
- R5: After a negative acknowledge, the next valid flit is taken as column parity. Its bits [65:0] appear on `iterColPar`, and `iterStart` pulses for exactly one cycle. `iterRows` holds the row-decoded codewords, with row r at bits [22r +: 22]. Correctable rows appear corrected and uncorrectable rows appear as received. No acknowledge is sent for the parity flit.
- R6: The three `ackNack` wires always carry the same value whenever `ackValid` is high.
- R7: While the block waits for `iterDone`, a valid flit is ignored. It produces no acknowledge and no output, and `iterColPar` stays unchanged.
- R8: On `iterDone`, the block drives `outValid`=1 with `outData`=`iterData` and `outErr`=`!iterOk` one clock later. No further acknowledge is sent.
- R9: A flit presented in the cycle in which a result is shown is accepted and decoded.
- R10: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received flit valid |
| rxFlit | input | 88 | Received flit (interleaved rows, or zero-padded column parity) |
| ackValid | output | 1 | Acknowledge response valid |
| ackNack | output | 3 | Triplicated response: 000 acknowledge, 111 negative acknowledge |
| outValid | output | 1 | Decoded message valid |
| outData | output | 64 | Decoded message |
| outErr | output | 1 | Message could not be repaired |
| iterStart | output | 1 | One-cycle start pulse to the iterative decoder |
| iterRows | output | 88 | Stored row-decoded codewords |
| iterColPar | output | 66 | Stored column check bits |
| iterDone | input | 1 | Iterative decoder finished |
| iterOk | input | 1 | Iterative decoder succeeded |
| iterData | input | 64 | Message returned by the iterative decoder |

## Verification
The bench injects one error at every one of the 88 flit positions, and one error in each of the four rows at once. A wrong deinterleave map or a wrong data-position map would return corrupted data while still acknowledging. Double errors are placed in every row, including pairs that involve the parity bit, and a triple error whose syndrome points past bit 21 is also sent. A decoder that took these as correctable would acknowledge garbage instead of asking for parity. The bench checks the stored rows and parity, sends a flit during the iterative wait, and sends a flit back-to-back with a result. A controller with a loose state machine would acknowledge twice, overwrite the parity, or drop the next message.

// File: rtl/harq_rx_pkg.sv
package harq_rx_pkg;

  // Hamming check bits needed to cover d data bits
  function automatic int chkBits(input int d);
    int r;
    r = 1;
    while ((1 << r) < d + r + 1) r++;
    return r;
  endfunction

  function automatic bit isPow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // codeword position of data bit k (positions that are not powers of two)
  function automatic int dataPos(input int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < k + 64; p++) begin
      if (!isPow2(p)) begin
        if (cnt == k && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROWDEC, ST_WAIT_PARITY, ST_ITERATE, ST_DONE
  } rx_state_t;

  typedef struct packed {
    logic captureFlit;
    logic emitAck;
    logic ackIsNack;
    logic loadRowBuf;
    logic emitRowOut;
    logic loadColPar;
    logic startIter;
    logic emitIterOut;
  } rx_strobes_t;

endpackage

// File: rtl/secded_row_dec.sv
module secded_row_dec #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 5,
  parameter int ROW_W  = 22
) (
  input  logic [ROW_W-1:0]  rowIn,
  output logic [ROW_W-1:0]  rowFixed,
  output logic [DATA_W-1:0] dataOut,
  output logic              uncorrectable
);
  import harq_rx_pkg::*;

  logic [CHK_W-1:0] syn;
  logic             par;

  always_comb begin
    syn = '0;
    for (int p = 1; p < ROW_W; p++) begin
      if (rowIn[p]) syn = syn ^ CHK_W'(p);
    end
    par = ^rowIn;
    uncorrectable = (!par && syn != '0) || (par && int'(syn) >= ROW_W);
    for (int p = 0; p < ROW_W; p++) begin
      rowFixed[p] = rowIn[p] ^ (par && syn == CHK_W'(p));
    end
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_data
    assign dataOut[k] = rowFixed[dataPos(k)];
  end

endmodule

// File: rtl/rx_row_dp.sv
module rx_row_dp #(
  parameter int ROWS     = 4,
  parameter int DATA_W   = 16,
  parameter int CHK_W    = 5,
  parameter int ROW_W    = 22,
  parameter int FLIT_W   = 88,
  parameter int MSG_W    = 64,
  parameter int COLPAR_W = 66
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  harq_rx_pkg::rx_strobes_t  st,
  input  logic [FLIT_W-1:0]         rxFlit,
  input  logic [MSG_W-1:0]          iterData,
  input  logic                      iterOk,
  output logic                      anyUncorr,
  output logic                      ackValid,
  output logic [2:0]                ackNack,
  output logic                      outValid,
  output logic [MSG_W-1:0]          outData,
  output logic                      outErr,
  output logic                      iterStart,
  output logic [FLIT_W-1:0]         iterRows,
  output logic [COLPAR_W-1:0]       iterColPar
);

  logic [FLIT_W-1:0] flitReg;
  logic [FLIT_W-1:0] fixedFlat;
  logic [MSG_W-1:0]  corrData;
  logic [ROWS-1:0]   badVec;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ROW_W-1:0]  recv;
    logic [ROW_W-1:0]  fixed;
    logic [DATA_W-1:0] data;
    logic              bad;
    for (genvar p = 0; p < ROW_W; p++) begin : g_bit
      assign recv[p] = flitReg[p*ROWS + r];
    end
    secded_row_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ROW_W(ROW_W)) i_dec (
      .rowIn(recv), .rowFixed(fixed), .dataOut(data), .uncorrectable(bad)
    );
    assign fixedFlat[r*ROW_W +: ROW_W]  = fixed;
    assign corrData[r*DATA_W +: DATA_W] = data;
    assign badVec[r]                     = bad;
  end

  assign anyUncorr = |badVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flitReg    <= '0;
      iterRows   <= '0;
      iterColPar <= '0;
      ackValid   <= 1'b0;
      ackNack    <= '0;
      outValid   <= 1'b0;
      outData    <= '0;
      outErr     <= 1'b0;
      iterStart  <= 1'b0;
    end else begin
      if (st.captureFlit) flitReg <= rxFlit;
      if (st.loadRowBuf)  iterRows <= fixedFlat;
      if (st.loadColPar)  iterColPar <= rxFlit[COLPAR_W-1:0];
      ackValid  <= st.emitAck;
      ackNack   <= st.emitAck ? {3{st.ackIsNack}} : 3'b000;
      outValid  <= st.emitRowOut | st.emitIterOut;
      iterStart <= st.startIter;
      if (st.emitRowOut) begin
        outData <= corrData;
        outErr  <= 1'b0;
      end else if (st.emitIterOut) begin
        outData <= iterData;
        outErr  <= !iterOk;
      end
    end
  end

  // R5: the start request to the iterative decoder is a single-cycle pulse
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    iterStart |=> !iterStart);

endmodule

// File: rtl/rx_row_ctrl.sv
module rx_row_ctrl (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rxValid,
  input  logic                      anyUncorr,
  input  logic                      iterDone,
  output harq_rx_pkg::rx_strobes_t  st
);
  import harq_rx_pkg::*;

  rx_state_t state, nextState;

  always_comb begin
    st        = '0;
    nextState = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (rxValid) begin
          st.captureFlit = 1'b1;
          nextState      = ST_ROWDEC;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_ROWDEC: begin
        st.emitAck = 1'b1;
        if (anyUncorr) begin
          st.ackIsNack  = 1'b1;
          st.loadRowBuf = 1'b1;
          nextState     = ST_WAIT_PARITY;
        end else begin
          st.emitRowOut = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_WAIT_PARITY: begin
        if (rxValid) begin
          st.loadColPar = 1'b1;
          st.startIter  = 1'b1;
          nextState     = ST_ITERATE;
        end
      end
      ST_ITERATE: begin
        if (iterDone) begin
          st.emitIterOut = 1'b1;
          nextState      = ST_DONE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R5: only one response per flit; none while parity or iteration is pending
  a_r5_one_response: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_PARITY || state == ST_ITERATE) |-> !st.emitAck);

  // R7: nothing is captured while the iterative decoder runs
  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITERATE) |-> !(st.captureFlit || st.loadColPar));

  // R4: a negative acknowledge is always followed by the parity wait
  a_r4_nack_waits: assert property (@(posedge clk) disable iff (!rstN)
    (st.emitAck && st.ackIsNack) |=> (state == ST_WAIT_PARITY));

endmodule

// File: rtl/harq_row_rx.sv
module harq_row_rx #(
  parameter  int ROWS     = 4,
  parameter  int DATA_W   = 16,
  localparam int CHK_W    = harq_rx_pkg::chkBits(DATA_W),
  localparam int ROW_W    = DATA_W + CHK_W + 1,
  localparam int FLIT_W   = ROWS * ROW_W,
  localparam int MSG_W    = ROWS * DATA_W,
  localparam int COLPAR_W = ROW_W * harq_rx_pkg::chkBits(ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic [FLIT_W-1:0]   rxFlit,
  output logic                ackValid,
  output logic [2:0]          ackNack,
  output logic                outValid,
  output logic [MSG_W-1:0]    outData,
  output logic                outErr,
  output logic                iterStart,
  output logic [FLIT_W-1:0]   iterRows,
  output logic [COLPAR_W-1:0] iterColPar,
  input  logic                iterDone,
  input  logic                iterOk,
  input  logic [MSG_W-1:0]    iterData
);
  import harq_rx_pkg::*;

  rx_strobes_t st;
  logic        anyUncorr;

  rx_row_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .anyUncorr(anyUncorr),
    .iterDone(iterDone), .st(st)
  );

  rx_row_dp #(
    .ROWS(ROWS), .DATA_W(DATA_W), .CHK_W(CHK_W), .ROW_W(ROW_W),
    .FLIT_W(FLIT_W), .MSG_W(MSG_W), .COLPAR_W(COLPAR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .rxFlit(rxFlit), .iterData(iterData),
    .iterOk(iterOk), .anyUncorr(anyUncorr), .ackValid(ackValid),
    .ackNack(ackNack), .outValid(outValid), .outData(outData), .outErr(outErr),
    .iterStart(iterStart), .iterRows(iterRows), .iterColPar(iterColPar)
  );

  // R3: a positive acknowledge comes with a clean message
  a_r3_ack_with_output: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackNack == 3'b000) |-> (outValid && !outErr));

  // R4: a negative acknowledge never comes with a message
  a_r4_nack_no_output: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackNack == 3'b111) |-> !outValid);

  // R6: the three response wires agree
  a_r6_ack_triplet: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackNack == 3'b000 || ackNack == 3'b111));

  // R10: after reset nothing is asserted
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> !(ackValid || outValid || iterStart));

endmodule

// File: tb/test_harq_row_rx.sv
`timescale 1ns/1ps
module test_harq_row_rx;

  localparam int NR = 4;
  localparam int DW = 16;
  localparam int RW = 22;
  localparam int FW = 88;
  localparam int MW = 64;
  localparam int PW = 66;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxValid = 1'b0;
  logic [FW-1:0] rxFlit = '0;
  logic          ackValid;
  logic [2:0]    ackNack;
  logic          outValid;
  logic [MW-1:0] outData;
  logic          outErr;
  logic          iterStart;
  logic [FW-1:0] iterRows;
  logic [PW-1:0] iterColPar;
  logic          iterDone = 1'b0;
  logic          iterOk = 1'b0;
  logic [MW-1:0] iterData = '0;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  harq_row_rx i_harq_row_rx (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxFlit(rxFlit),
    .ackValid(ackValid), .ackNack(ackNack), .outValid(outValid),
    .outData(outData), .outErr(outErr), .iterStart(iterStart),
    .iterRows(iterRows), .iterColPar(iterColPar), .iterDone(iterDone),
    .iterOk(iterOk), .iterData(iterData)
  );

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // row layout per R1
  function automatic logic [RW-1:0] encRow(input logic [DW-1:0] d);
    logic [RW-1:0] cw;
    int k;
    logic b;
    cw = '0;
    k = 0;
    for (int p = 1; p < RW; p++) begin
      if (!pow2(p)) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < 5; i++) begin
      b = 1'b0;
      for (int p = 1; p < RW; p++) if (((p >> i) & 1) == 1) b = b ^ cw[p];
      cw[1 << i] = b;
    end
    cw[0] = ^cw[RW-1:1];
    return cw;
  endfunction

  function automatic logic [FW-1:0] weave(input logic [RW-1:0] r0, r1, r2, r3);
    logic [FW-1:0] f;
    for (int p = 0; p < RW; p++) begin
      f[p*NR + 0] = r0[p];
      f[p*NR + 1] = r1[p];
      f[p*NR + 2] = r2[p];
      f[p*NR + 3] = r3[p];
    end
    return f;
  endfunction

  function automatic logic [FW-1:0] buildFlit(input logic [MW-1:0] m);
    return weave(encRow(m[15:0]), encRow(m[31:16]), encRow(m[47:32]), encRow(m[63:48]));
  endfunction

  // drive a flit at the current falling edge, check the response one clock after capture
  task automatic sendExpectAck(input logic [FW-1:0] f, input logic [MW-1:0] m, input string req);
    rxValid = 1'b1;
    rxFlit  = f;
    @(negedge clk);
    rxValid = 1'b0;
    rxFlit  = '0;
    @(negedge clk);
    chk(ackValid && ackNack == 3'b000, {req, " R3 ack"}, FW'({ackValid, ackNack}), FW'(4'b1000));
    chk(outValid && !outErr, {req, " R3 valid"}, FW'({outValid, outErr}), FW'(2'b10));
    chk(outData == m, {req, " data"}, FW'(outData), FW'(m));
  endtask

  // full negative-acknowledge flow; flips are row bit positions, -1 skips
  task automatic runNack(input logic [MW-1:0] m, input int dRow, input int pa, input int pb,
                         input int pc, input int sRow, input int sPos, input bit ok,
                         input logic [PW-1:0] par);
    logic [RW-1:0] clean [NR];
    logic [RW-1:0] recv [NR];
    logic [FW-1:0] expRows;
    logic [MW-1:0] ret;
    for (int r = 0; r < NR; r++) begin
      clean[r] = encRow(m[r*DW +: DW]);
      recv[r]  = clean[r];
    end
    recv[dRow][pa] = ~recv[dRow][pa];
    recv[dRow][pb] = ~recv[dRow][pb];
    if (pc >= 0) recv[dRow][pc] = ~recv[dRow][pc];
    if (sRow >= 0) recv[sRow][sPos] = ~recv[sRow][sPos];
    for (int r = 0; r < NR; r++) expRows[r*RW +: RW] = (r == dRow) ? recv[r] : clean[r];
    rxValid = 1'b1;
    rxFlit  = weave(recv[0], recv[1], recv[2], recv[3]);
    @(negedge clk);
    rxValid = 1'b0;
    @(negedge clk);
    chk(ackValid && ackNack == 3'b111, "R4 nack", FW'({ackValid, ackNack}), FW'(4'b1111));
    chk(!outValid, "R4 no output on nack", FW'(outValid), '0);
    // parity flit, zero padded
    rxValid = 1'b1;
    rxFlit  = {22'h0, par};
    @(negedge clk);
    chk(iterStart == 1'b1, "R5 start", FW'(iterStart), FW'(1));
    chk(iterColPar == par, "R5 colpar", FW'(iterColPar), FW'(par));
    chk(iterRows == expRows, "R5 rows", iterRows, expRows);
    chk(!ackValid && !outValid, "R5 no ack for parity", FW'({ackValid, outValid}), '0);
    // flit during iteration must be ignored
    rxFlit = ~{22'h0, par};
    @(negedge clk);
    rxValid = 1'b0;
    rxFlit  = '0;
    chk(!iterStart, "R5 start pulse ends", FW'(iterStart), '0);
    chk(!ackValid && !outValid, "R7 busy flit ignored", FW'({ackValid, outValid}), '0);
    @(negedge clk);
    chk(!ackValid && !outValid, "R7 busy flit ignored later", FW'({ackValid, outValid}), '0);
    chk(iterColPar == par, "R7 colpar kept", FW'(iterColPar), FW'(par));
    ret = ok ? m : (m ^ 64'hFFFF_0000_FFFF_0000);
    iterDone = 1'b1;
    iterOk   = ok;
    iterData = ret;
    @(negedge clk);
    iterDone = 1'b0;
    chk(outValid && outErr == !ok, "R8 output flag", FW'({outValid, outErr}), FW'({1'b1, !ok}));
    chk(outData == ret, "R8 output data", FW'(outData), FW'(ret));
    chk(!ackValid, "R8 no second response", FW'(ackValid), '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    logic [MW-1:0] m;
    logic [FW-1:0] f;
    repeat (3) @(negedge clk);
    chk({ackValid, outValid, outErr, iterStart} == 4'b0 && outData == '0 &&
        iterRows == '0 && iterColPar == '0 && ackNack == 3'b0,
        "R10 reset state", FW'({ackValid, outValid, outErr, iterStart}), '0);
    rstN = 1'b1;
    @(negedge clk);

    // error-free messages
    for (int i = 0; i < 6; i++) begin
      m = (i == 0) ? 64'h0 : (i == 1) ? '1 : 64'hA5A5_5A5A_0FF0_F00F * (i + 1);
      sendExpectAck(buildFlit(m), m, "R1 clean");
    end

    // one error at every flit position
    for (int b = 0; b < FW; b++) begin
      m = {16'h1234 ^ 16'(b), 16'hBEEF + 16'(b), 16'(b * 977), ~16'(b)};
      f = buildFlit(m);
      f[b] = ~f[b];
      sendExpectAck(f, m, "R2 single flit bit");
    end

    // one error in every row at once
    for (int p = 0; p < RW; p++) begin
      logic [RW-1:0] rw [NR];
      m = {16'(p * 3001), 16'hC3C3 ^ 16'(p), 16'(p << 7), 16'h8001 + 16'(p)};
      for (int r = 0; r < NR; r++) begin
        rw[r] = encRow(m[r*DW +: DW]);
        rw[r][(p + 5*r) % RW] = ~rw[r][(p + 5*r) % RW];
      end
      sendExpectAck(weave(rw[0], rw[1], rw[2], rw[3]), m, "R2 four rows");
    end

    // double errors in each row, back-to-back with results (R9)
    for (int r = 0; r < NR; r++) begin
      runNack(64'h0123_4567_89AB_CDEF ^ MW'(r), r, 0, 7 + r, -1, (r + 1) % NR, 3 + r,
              (r % 2) == 0, {2'b10, 64'hDEAD_BEEF_0000_0000 | MW'(r)});
      runNack(64'hFEDC_BA98_7654_3210 + MW'(r), r, 3, 21, -1, -1, 0,
              1'b1, {2'b01, 64'h1357_9BDF_2468_ACE0 ^ MW'(r)});
      runNack(64'h5555_AAAA_3333_CCCC, r, 1, 16, -1, (r + 2) % NR, 0,
              1'b0, {2'b11, 64'h0F0F_0F0F_0F0F_0F0F});
    end
    // triple error whose syndrome points past the row (2 ^ 4 ^ 16 = 22)
    runNack(64'h7777_8888_9999_AAAA, 2, 2, 4, 16, -1, 0, 1'b1, {2'b00, 64'hCAFE_F00D_1234_5678});

    // R9: flit sent right after an iterative result is accepted
    m = 64'h0BAD_CAFE_DEAD_C0DE;
    sendExpectAck(buildFlit(m), m, "R9 after iteration");

    // R6: every response above already checked for all-equal wires; one more explicit
    chk(ackNack == 3'b000 || ackNack == 3'b111, "R6 triplet", FW'(ackNack), FW'(ackNack[0] ? 3'b111 : 3'b000));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule